// File: doc/BRIEF.md
# Immediate Command and Response Port

This block gives software a polled path for sending one command word to the codec link and collecting the one reply, without the command and response rings. Software loads a 32-bit command into the command register. It then sets the busy flag in the status register. The block offers the stored word on a valid/ready output. It then watches the response input for the first solicited reply, stores that reply in the response register, and signals completion by setting the reply-valid flag and dropping busy.

Software talks to the block through a plain register port. One write strobe and one address serve both reads and writes, and the read data is combinational on the address. The map is:

| Address | Register | Access |
|---------|----------|--------|
| 0 | command | read/write |
| 1 | response | read-only |
| 2 | status | read/write |
| 3 | unused | reads 0 |

The status register is 16 bits wide and is zero-extended on the read bus. Bit 0 is busy. Bit 1 is reply-valid, which is cleared by writing 1 to it.

A three-state machine sequences the exchange. `ST_IDLE` waits for a launch; a launch moves it to `ST_ISSUE`. `ST_ISSUE` drives the command valid output. When ready is seen, the handshake moves it to `ST_AWAIT`. `ST_AWAIT` ignores unsolicited replies. When a solicited reply is captured, it returns to `ST_IDLE`.

Top module: `imm_cmd_port`

## Requirements
- R1: After reset the status, response and command registers read 0, and `link_cmd_valid` is 0.
- R2: A write to address 0 while busy is 0 stores the word, and address 0 reads it back. Writes to the response register (address 1) have no effect, and address 3 reads 0.
- R3: A write to address 0 while busy is 1 is ignored, and the command register keeps its earlier value.
- R4: Writing status with bit 0 set while busy is 0 sets busy. `link_cmd_valid` rises on the next cycle carrying the command register value, and stays high with stable data until the cycle in which `link_cmd_ready` is 1.
- R5: Writing status bit 0 while busy is already 1 has no effect. No second command is offered after the reply arrives.
- R6: A reply with `link_rsp_valid`=1 and `link_rsp_unsol`=0, seen after the command handshake, is stored in the response register. In the same cycle, reply-valid (status bit 1) is set and busy (status bit 0) is cleared.
- R7: Writing status with bit 1 set clears reply-valid, and writing 0 there leaves it unchanged. A capture in the same cycle as a clearing write leaves reply-valid set.
- R8: A reply with `link_rsp_unsol`=1 is never captured. Busy stays 1, and reply-valid and the response register are unchanged.
- R9: Replies that arrive while idle, or before the command handshake completes, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| link_cmd_valid | output | 1 | Command word offered to the link |
| link_cmd_ready | input | 1 | Link accepts the command word |
| link_cmd_data | output | 32 | Command word |
| link_rsp_valid | input | 1 | Reply present on the link input |
| link_rsp_unsol | input | 1 | Reply is unsolicited |
| link_rsp_data | input | 32 | Reply word |

## Verification
A wrong state shows up at the ports within one cycle. A stuck or early-cleared busy flag reads back wrongly in status bit 0 on the next access. A skipped or repeated launch shows as a missing or extra `link_cmd_valid` cycle right after the launching write. A reply captured in the wrong state, or an unsolicited one, changes the response register and the reply-valid flag at the next read. The bench keeps a behavioural model of busy, handshake-done, reply-valid and both data registers. It compares the read port and the command output against that model on every clock, so a divergence is reported in the cycle it appears.

// File: rtl/imm_pkg.sv
package imm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } imm_state_e;

    localparam int unsigned ADDR_W     = 2;
    localparam logic [1:0]  REG_CMD    = 2'd0;
    localparam logic [1:0]  REG_RSP    = 2'd1;
    localparam logic [1:0]  REG_STAT   = 2'd2;
    localparam int unsigned BUSY_BIT   = 0;
    localparam int unsigned VALID_BIT  = 1;

endpackage

// File: rtl/imm_seq.sv
module imm_seq
    import imm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic link_cmd_ready,
    input  logic link_rsp_valid,
    input  logic link_rsp_unsol,
    output logic busy,
    output logic issue,
    output logic capture
);

    imm_state_e state_q;
    imm_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_req) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (link_cmd_ready) begin
                    state_d = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (link_rsp_valid && !link_rsp_unsol) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        issue   = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_ISSUE: begin
                busy  = 1'b1;
                issue = 1'b1;
            end
            ST_AWAIT: begin
                busy    = 1'b1;
                capture = link_rsp_valid && !link_rsp_unsol;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R4: offer held until accepted
    p_issue_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !link_cmd_ready |=> issue);

    // R6: capture ends the exchange
    p_capture_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !busy);

    // R8: unsolicited reply keeps waiting
    p_unsol_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAIT) && link_rsp_valid && link_rsp_unsol |=> busy && !issue);

    // R5: no second offer straight after the wait
    p_no_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAIT) |=> !issue);

    // R9: nothing captured outside the wait state
    p_no_early_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_AWAIT) |-> !capture);

endmodule

// File: rtl/imm_regs.sv
module imm_regs
    import imm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              capture,
    input  logic [DATA_W-1:0] rsp_in,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              launch_req
);

    localparam int unsigned PAD_W = DATA_W - STAT_W;

    logic [DATA_W-1:0] rsp_q;
    logic              valid_q;
    logic              wr_cmd;
    logic              wr_stat;
    logic              clr_valid;
    logic [STAT_W-1:0] stat_word;

    assign wr_cmd     = reg_wr && (reg_addr == REG_CMD);
    assign wr_stat    = reg_wr && (reg_addr == REG_STAT);
    assign clr_valid  = wr_stat && reg_wdata[VALID_BIT];
    assign launch_req = wr_stat && reg_wdata[BUSY_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd && !busy) begin
            cmd_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (capture) begin
            rsp_q <= rsp_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (capture) begin
            valid_q <= 1'b1;
        end else if (clr_valid) begin
            valid_q <= 1'b0;
        end
    end

    always_comb begin
        stat_word            = '0;
        stat_word[BUSY_BIT]  = busy;
        stat_word[VALID_BIT] = valid_q;
    end

    always_comb begin
        unique case (reg_addr)
            REG_CMD:  reg_rdata = cmd_q;
            REG_RSP:  reg_rdata = rsp_q;
            REG_STAT: reg_rdata = {{PAD_W{1'b0}}, stat_word};
            default:  reg_rdata = '0;
        endcase
    end

    // R3: command locked while busy
    p_cmd_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));

    // R7: clearing write without capture drops valid
    p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid && !capture |=> !valid_q);

    // R7: capture wins over a clear in the same cycle
    p_capture_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> valid_q && (rsp_q == $past(rsp_in)));

    // R8/R9: response register moves only on capture
    p_rsp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rsp_q));

endmodule

// File: rtl/imm_cmd_port.sv
module imm_cmd_port
    import imm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              link_cmd_valid,
    input  logic              link_cmd_ready,
    output logic [DATA_W-1:0] link_cmd_data,
    input  logic              link_rsp_valid,
    input  logic              link_rsp_unsol,
    input  logic [DATA_W-1:0] link_rsp_data
);

    logic busy;
    logic issue;
    logic capture;
    logic launch_req;
    logic [DATA_W-1:0] cmd_q;

    imm_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_req     (launch_req),
        .link_cmd_ready (link_cmd_ready),
        .link_rsp_valid (link_rsp_valid),
        .link_rsp_unsol (link_rsp_unsol),
        .busy           (busy),
        .issue          (issue),
        .capture        (capture)
    );

    imm_regs #(
        .DATA_W (DATA_W),
        .STAT_W (STAT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .capture    (capture),
        .rsp_in     (link_rsp_data),
        .cmd_q      (cmd_q),
        .reg_rdata  (reg_rdata),
        .launch_req (launch_req)
    );

    assign link_cmd_valid = issue;
    assign link_cmd_data  = cmd_q;

    // R4: launch from idle offers the command next cycle
    p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == REG_STAT) && reg_wdata[BUSY_BIT] && !busy
        |=> link_cmd_valid && (link_cmd_data == $past(cmd_q)));

    // R4: offered data stable until accepted
    p_cmd_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_cmd_valid && !link_cmd_ready |=> $stable(link_cmd_data));

endmodule

// File: tb/tb_imm_cmd_port.sv
module tb_imm_cmd_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_cmd_valid;
    logic        link_cmd_ready = 1'b0;
    logic [31:0] link_cmd_data;
    logic        link_rsp_valid = 1'b0;
    logic        link_rsp_unsol = 1'b0;
    logic [31:0] link_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model
    bit        m_busy, m_sent, m_valid;
    bit [31:0] m_cmd, m_rsp;

    imm_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_cmd_valid(link_cmd_valid), .link_cmd_ready(link_cmd_ready),
        .link_cmd_data(link_cmd_data), .link_rsp_valid(link_rsp_valid),
        .link_rsp_unsol(link_rsp_unsol), .link_rsp_data(link_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_cmd;
            2'd1:    return m_rsp;
            2'd2:    return {30'd0, m_valid, m_busy};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit ob, os;
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_sent = 0; m_valid = 0; m_cmd = '0; m_rsp = '0;
        end else begin
            ob = m_busy; os = m_sent;
            if (reg_wr && reg_addr == 2'd0 && !ob) m_cmd = reg_wdata;
            if (reg_wr && reg_addr == 2'd2 && reg_wdata[1]) m_valid = 0;
            if (reg_wr && reg_addr == 2'd2 && reg_wdata[0] && !ob) begin
                m_busy = 1; m_sent = 0;
            end
            if (ob && !os && link_cmd_ready) m_sent = 1;
            if (ob && os && link_rsp_valid && !link_rsp_unsol) begin
                m_rsp = link_rsp_data; m_valid = 1; m_busy = 0; m_sent = 0;
            end
        end
    end

    // every-clock comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(reg_addr == 2'd2 ? "R6 status vs model" :
                reg_addr == 2'd1 ? "R6 response vs model" : "R2 read vs model",
                reg_rdata, model_read(reg_addr));
            chk("R4 cmd_valid vs model", {31'd0, link_cmd_valid}, {31'd0, m_busy && !m_sent});
            if (m_busy && !m_sent)
                chk("R4 cmd_data vs model", link_cmd_data, m_cmd);
        end
    end

    always @(posedge clk) begin
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                        input logic rdy, input logic rv, input logic un,
                        input logic [31:0] rd);
        @(negedge clk);
        #1;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        link_cmd_ready = rdy; link_rsp_valid = rv; link_rsp_unsol = un;
        link_rsp_data = rd;
    endtask

    task automatic idle();
        step(0, reg_addr, '0, 0, 0, 0, '0);
    endtask

    task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
        step(0, a, '0, 0, 0, 0, '0);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        peek(2, 32'd0, "R1 status");
        peek(1, 32'd0, "R1 response");
        peek(0, 32'd0, "R1 command");
        chk("R1 cmd_valid", {31'd0, link_cmd_valid}, 32'd0);

        // R2 command store and read-back
        step(1, 0, 32'hA5A5_0001, 0, 0, 0, '0);
        peek(0, 32'hA5A5_0001, "R2 command readback");
        peek(3, 32'd0, "R2 unused address");

        // R9 reply while idle
        step(0, 0, '0, 0, 1, 0, 32'hDEAD_0000);
        peek(2, 32'd0, "R9 status after idle reply");
        peek(1, 32'd0, "R9 response after idle reply");

        // R4 launch
        step(1, 2, 32'd1, 0, 0, 0, '0);
        peek(2, 32'd1, "R4 busy set");
        chk("R4 offer raised", {31'd0, link_cmd_valid}, 32'd1);
        chk("R4 offer data", link_cmd_data, 32'hA5A5_0001);
        step(0, 2, '0, 0, 1, 0, 32'hBEEF_0000);          // R9 early reply
        step(1, 0, 32'h1234_5678, 0, 0, 0, '0);          // R3 write while busy
        peek(0, 32'hA5A5_0001, "R3 command unchanged");
        step(1, 2, 32'd1, 0, 0, 0, '0);                  // R5 relaunch while busy
        #1 chk("R4 offer held", {31'd0, link_cmd_valid}, 32'd1);
        peek(1, 32'd0, "R9 early reply ignored");
        step(0, 2, '0, 1, 0, 0, '0);                     // handshake
        peek(2, 32'd1, "R4 still busy after handshake");
        chk("R4 offer dropped", {31'd0, link_cmd_valid}, 32'd0);

        // R8 unsolicited reply
        step(0, 2, '0, 0, 1, 1, 32'h0BAD_0BAD);
        peek(2, 32'd1, "R8 busy kept");
        peek(1, 32'd0, "R8 response unchanged");

        // R6 solicited reply
        step(0, 2, '0, 0, 1, 0, 32'h1111_2222);
        peek(2, 32'd2, "R6 valid set busy clear");
        peek(1, 32'h1111_2222, "R6 response stored");
        idle(); idle();
        #1 chk("R5 no second offer", {31'd0, link_cmd_valid}, 32'd0);

        // R7 clearing rules
        step(1, 2, 32'd0, 0, 0, 0, '0);
        peek(2, 32'd2, "R7 write 0 keeps valid");
        step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, '0);
        peek(1, 32'h1111_2222, "R2 response read-only");
        step(1, 2, 32'd2, 0, 0, 0, '0);
        peek(2, 32'd0, "R7 write 1 clears valid");

        // R7 capture beats clear
        step(1, 0, 32'h3333_0000, 0, 0, 0, '0);
        step(1, 2, 32'd1, 0, 0, 0, '0);
        step(0, 2, '0, 1, 0, 0, '0);
        step(1, 2, 32'd2, 0, 1, 0, 32'h4444_0000);
        peek(2, 32'd2, "R7 capture wins over clear");
        peek(1, 32'h4444_0000, "R6 second response");

        // R7 clear and launch together
        step(1, 2, 32'd3, 0, 0, 0, '0);
        peek(2, 32'd1, "R7 clear with launch");
        step(0, 2, '0, 1, 0, 0, '0);
        step(0, 2, '0, 0, 1, 0, 32'h5555_0000);
        peek(1, 32'h5555_0000, "R6 third response");

        // varied latencies
        for (int i = 0; i < 8; i++) begin
            step(1, 2, 32'd2, 0, 0, 0, '0);
            step(1, 0, 32'h0101_0101 * i + 32'd5, 0, 0, 0, '0);
            step(1, 2, 32'd1, 0, 0, 0, '0);
            for (int k = 0; k < i % 3; k++) step(0, 2, '0, 0, (k == 0), 0, 32'hEEEE_0000);
            step(0, 2, '0, 1, 0, 0, '0);
            for (int k = 0; k < i % 4; k++) step(0, 2, '0, 0, 1, 1, 32'hCCCC_0000);
            step(0, 2, '0, 0, 1, 0, ~32'(i));
            peek(2, 32'd2, "R6 loop status");
            peek(1, ~32'(i), "R6 loop response");
        end

        idle(); idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule